// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, A and B, of a parameterised width (8 bits by default). Each direction has its own holding register with its own clock. The A-side register samples the A bus and the B-side register samples the B bus. Each bus can be driven by the block through a selector. The selector passes either the opposite bus live or the value held in the matching register. Two enables with opposite polarity decide which bus the block drives. When both buses are driven, the held values are exchanged.

Each bus side is modelled as three separate ports: an external input, a block output and an output-enable flag. No tri-state nets are used. A register samples the "bus view" of its side. The bus view is the block's own output when that side is driven and the external input otherwise. Because of this, a single edge can copy one bus into both registers. The live path always takes the opposite side's external input, so no combinational loop can form.

Top module: `bus_xcvr_reg`

## Requirements
- R1: With `en_ab` = 0 and `en_ba_n` = 1, both `a_oe` and `b_oe` are 0, so neither bus is driven.
- R2: On every rising edge of `clk_ab`, the A-side register loads the A bus view, whatever the enables and selects are. The A bus view is `a_out` when `a_oe` = 1 and `a_in` otherwise.
- R3: On every rising edge of `clk_ba`, the B-side register loads the B bus view, whatever the enables and selects are. The B bus view is `b_out` when `b_oe` = 1 and `b_in` otherwise.
- R4: `b_oe` equals `en_ab` (active high). While `b_oe` = 1, `b_out` equals `a_in` when `sel_ab` = 0 and equals the A-side register when `sel_ab` = 1.
- R5: `a_oe` equals the inverse of `en_ba_n` (active low). While `a_oe` = 1, `a_out` equals `b_in` when `sel_ba` = 0 and equals the B-side register when `sel_ba` = 1.
- R6: With `en_ab` = 1, `en_ba_n` = 0 and both selects at 1, both buses are driven at once: `b_out` carries the A-side register and `a_out` carries the B-side register.
- R7: While B is driven with `sel_ab` = 0, a `clk_ba` edge loads `a_in` into the B-side register. If `clk_ab` rises on the same edge, A is loaded into both registers.
- R8: While A is driven with `sel_ba` = 0, a `clk_ab` edge loads `b_in` into the A-side register. If `clk_ba` rises on the same edge, B is loaded into both registers.
- R9: When a driven side's select is 1 and both clocks rise together, each register takes the value its bus view had just before the edge. That value is the other register's old content, never its newly loaded one.
- R10: An active-low asynchronous `rst_n` clears both registers to 0.
- R11: A bus output that is not enabled reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| en_ab | input | 1 | Drive enable for bus B, active high |
| en_ba_n | input | 1 | Drive enable for bus A, active low |
| sel_ab | input | 1 | B source: 0 live A, 1 A-side register |
| sel_ba | input | 1 | A source: 0 live B, 1 B-side register |
| a_in | input | W | External value on bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | External value on bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
The assertions check four things at all times: the enable decode and isolation, which source feeds each driven bus, the stored-value exchange and the zero on undriven outputs. On every clock edge they also check that each register holds the bus view from its previous edge. Only the bench's scenarios can show the cross-loading effects. These cover a driven bus being copied into both registers on one edge, and the pre-edge sampling under simultaneous edges with a select high. The bench sweeps every enable, select and clock combination and reads the registers back through the outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source chosen for a driven bus: live opposite input or held register.
  function automatic logic [63:0] pick_src(input logic [63:0] live,
                                           input logic [63:0] held,
                                           input logic sel);
    return sel ? held : live;
  endfunction

  // Value a register sees on its own side of the link.
  function automatic logic [63:0] bus_view(input logic [63:0] ext,
                                           input logic [63:0] own,
                                           input logic oe);
    return oe ? own : ext;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  // Held value equals the bus view sampled at the previous edge.
  AST_HOLDS_LAST_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> q == $past(d)); // R2, R3

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int W       = 8,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic         oe,
  output logic [W-1:0] out
);
  import xcvr_pkg::*;

  logic [63:0] chosen;

  generate
    if (ACT_LOW) begin : g_low
      assign oe = ~en;
    end else begin : g_high
      assign oe = en;
    end
  endgenerate

  assign chosen = pick_src(64'(live), 64'(held), sel);
  assign out    = oe ? chosen[W-1:0] : '0;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  logic [W-1:0] held_a, held_b;
  logic [63:0]  view_a_w, view_b_w;
  logic [W-1:0] view_a, view_b;

  // Bus views seen by each capture register.
  assign view_a_w = bus_view(64'(a_in), 64'(a_out), a_oe);
  assign view_b_w = bus_view(64'(b_in), 64'(b_out), b_oe);
  assign view_a   = view_a_w[W-1:0];
  assign view_b   = view_b_w[W-1:0];

  xcvr_store #(.W(W)) u_store_a (
    .clk(clk_ab), .rst_n(rst_n), .d(view_a), .q(held_a)
  );

  xcvr_store #(.W(W)) u_store_b (
    .clk(clk_ba), .rst_n(rst_n), .d(view_b), .q(held_b)
  );

  // A-to-B path, enable active high.
  xcvr_dir #(.W(W), .ACT_LOW(1'b0)) u_dir_ab (
    .en(en_ab), .sel(sel_ab), .live(a_in), .held(held_a),
    .oe(b_oe), .out(b_out)
  );

  // B-to-A path, enable active low.
  xcvr_dir #(.W(W), .ACT_LOW(1'b1)) u_dir_ba (
    .en(en_ba_n), .sel(sel_ba), .live(b_in), .held(held_b),
    .oe(a_oe), .out(a_out)
  );

  always_comb begin
    if (rst_n) begin
      if (!en_ab && en_ba_n)
        AST_ISOLATED: assert (!a_oe && !b_oe); // R1
      if (b_oe && sel_ab)
        AST_B_FROM_HELD: assert (b_out == held_a); // R4
      if (b_oe && !sel_ab)
        AST_B_FROM_LIVE: assert (b_out == a_in); // R4
      if (a_oe && sel_ba)
        AST_A_FROM_HELD: assert (a_out == held_b); // R5
      if (a_oe && !sel_ba)
        AST_A_FROM_LIVE: assert (a_out == b_in); // R5
      if (a_oe && b_oe && sel_ab && sel_ba)
        AST_EXCHANGE: assert (b_out == held_a && a_out == held_b); // R6
      if (!b_oe)
        AST_B_IDLE_ZERO: assert (b_out == '0); // R11
      if (!a_oe)
        AST_A_IDLE_ZERO: assert (a_out == '0); // R11
    end
  end

endmodule

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic g_ab = 1'b0, g_ba = 1'b0;
  logic rst_n = 1'b0;
  logic en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic clk_ab, clk_ba;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz
  assign clk_ab = clk & g_ab;
  assign clk_ba = clk & g_ba;

  bus_xcvr_reg #(.W(W)) u0 (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic pa, input logic pb);
    @(negedge clk);
    g_ab = pa; g_ba = pb;
    @(negedge clk);
    g_ab = 1'b0; g_ba = 1'b0;
    #1;
  endtask

  // Both outputs show the held values (R6 readback setting).
  task automatic readback(output logic [W-1:0] ra, output logic [W-1:0] rb);
    en_ab = 1'b1; en_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    #1;
    ra = b_out; rb = a_out;
  endtask

  task automatic preload(input logic [W-1:0] x, input logic [W-1:0] y);
    en_ab = 1'b0; en_ba_n = 1'b1; a_in = x; b_in = y;
    pulse(1'b1, 1'b1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        mismatched++; compared++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    #3;
    readback(ra, rb);
    check("R10 reset A reg", ra, '0);
    check("R10 reset B reg", rb, '0);
    rst_n = 1'b1;

    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 4; s++)
        for (int c = 1; c < 4; c++)
          for (int p = 0; p < 2; p++) begin
            logic [W-1:0] ra0, rb0, ai, bi, eb, ea, va, vb, xa, xb;
            logic xen_ab, xen_ba_n, xs_ab, xs_ba, xaoe, xboe, pa, pb;
            ra0 = W'(8'h11 * (e + 1) + p);
            rb0 = W'(8'hA0 ^ (s * 8'h13) ^ (p << 6));
            ai  = W'(8'h3C + c * 8'h21 + p);
            bi  = W'(8'hC5 - c * 8'h17 - e);
            preload(ra0, rb0);
            xen_ab = e[0]; xen_ba_n = e[1]; xs_ab = s[0]; xs_ba = s[1];
            pa = c[0]; pb = c[1];
            // Bench model, written from the requirements.
            xboe = xen_ab;
            xaoe = !xen_ba_n;
            eb = !xboe ? '0 : (xs_ab ? ra0 : ai);
            ea = !xaoe ? '0 : (xs_ba ? rb0 : bi);
            va = xaoe ? ea : ai;
            vb = xboe ? eb : bi;
            xa = pa ? va : ra0;
            xb = pb ? vb : rb0;

            en_ab = xen_ab; en_ba_n = xen_ba_n; sel_ab = xs_ab; sel_ba = xs_ba;
            a_in = ai; b_in = bi;
            #1;
            if (!xen_ab && xen_ba_n) begin
              check("R1 isolate a_oe", W'(a_oe), '0);
              check("R1 isolate b_oe", W'(b_oe), '0);
            end
            check("R4 b_oe", W'(b_oe), W'(xboe));
            check("R5 a_oe", W'(a_oe), W'(xaoe));
            if (!xboe) check("R11 b_out idle", b_out, eb);
            else if (xaoe && xs_ab && xs_ba) check("R6 b_out exchange", b_out, eb);
            else check("R4 b_out source", b_out, eb);
            if (!xaoe) check("R11 a_out idle", a_out, ea);
            else if (xboe && xs_ab && xs_ba) check("R6 a_out exchange", a_out, ea);
            else check("R5 a_out source", a_out, ea);

            pulse(pa, pb);
            readback(ra, rb);
            if (xaoe && xs_ba && pb) check("R9 A reg pre-edge", ra, xa);
            else if (xaoe) check("R8 A reg from driven A", ra, xa);
            else check("R2 A reg capture", ra, xa);
            if (xboe && xs_ab && pa) check("R9 B reg pre-edge", rb, xb);
            else if (xboe) check("R7 B reg from driven B", rb, xb);
            else check("R3 B reg capture", rb, xb);
          end

    // Asynchronous clear mid-run (R10).
    preload(W'(8'h5A), W'(8'hA5));
    #2 rst_n = 1'b0;
    #1;
    readback(ra, rb);
    check("R10 async clear A", ra, '0);
    check("R10 async clear B", rb, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule